// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller of a five-stage in-order pipeline. The stages are fetch, decode, execute, memory and writeback, and in steady state one instruction retires per cycle. The controller takes the register indices, source-use flags and write enables held in the decode, execute, memory and writeback stage registers. From them it makes four kinds of output. Two bypass selects choose where each execute-stage operand comes from. Hold signals freeze the program counter and the fetch/decode register. A clear signal empties the fetch/decode register. A bubble signal turns the next decode/execute register contents into a no-op.

A dependence is a read-after-write hazard: a source in decode or execute names a register that an older, still in-flight instruction will write. With bypassing on, most dependences are resolved by routing a result straight to the execute operand. A loaded value cannot be routed in time for the next instruction, so a load followed by a user of its result costs one stall cycle. A configuration input turns bypassing off. The pipeline then stalls every dependent instruction until its producer reaches writeback, which costs two bubbles for back-to-back dependence. Branches resolve in execute. A taken branch discards the two younger instructions, the ones in fetch and decode. The register file is taken to return, in the same cycle, a value that is being written in that cycle.

The block is purely combinational between its stage inputs and its control outputs. The clock and reset serve only the embedded checks.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: Select encoding is 2'b00 register file, 2'b01 memory-stage result, 2'b10 writeback-stage result. A write-enabled memory-stage destination equal to an execute source gives 2'b01 for that operand.
- R2: A write-enabled writeback destination equal to an execute source gives 2'b10, unless the memory stage also matches, in which case 2'b01 is chosen.
- R3: Register index 0 is never forwarded and never causes a stall.
- R4: A stage whose write enable is low neither forwards nor causes a stall.
- R5: With bypassing on, a load in execute whose destination equals a used decode source raises pc_hold, fd_hold and de_bubble for that cycle. A non-load producer in execute or memory does not stall, and a dependent instruction that follows a load sees exactly one stall cycle and then takes its operand from writeback (2'b10).
- R6: A decode source whose use flag is low never causes a stall.
- R7: With fwd_disable high, both selects are 2'b00. A used decode source that equals a write-enabled destination in execute or memory stalls, while a match only in writeback does not stall. Back-to-back dependence costs two stall cycles.
- R8: A taken branch in execute raises fd_flush and de_bubble and forces pc_hold and fd_hold low, overriding any stall in the same cycle. The two younger instructions never reach writeback.
- R9: With no dependence and no taken branch, all control outputs are low and both selects are 2'b00, including under reset with idle inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst | input | 1 | Synchronous active-high reset, disables checks |
| fwd_disable | input | 1 | High turns bypassing off; dependences stall instead |
| dec_rs1 | input | IDX_W | First source index of the decode instruction |
| dec_rs2 | input | IDX_W | Second source index of the decode instruction |
| dec_use_rs1 | input | 1 | Decode instruction reads its first source |
| dec_use_rs2 | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | IDX_W | First source index of the execute instruction |
| ex_rs2 | input | IDX_W | Second source index of the execute instruction |
| ex_rd | input | IDX_W | Destination index of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_br_taken | input | 1 | Branch in execute resolved taken |
| mem_rd | input | IDX_W | Destination index in the memory stage |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| wb_rd | input | IDX_W | Destination index in the writeback stage |
| wb_we | input | 1 | Writeback instruction writes a register |
| fwd_a_sel | output | 2 | Source select for execute operand 1 |
| fwd_b_sel | output | 2 | Source select for execute operand 2 |
| pc_hold | output | 1 | Freeze the program counter |
| fd_hold | output | 1 | Freeze the fetch/decode register |
| fd_flush | output | 1 | Clear the fetch/decode register |
| de_bubble | output | 1 | Load a no-op into the decode/execute register |

## Verification
The checks take the stage inputs to be the settled contents of the pipeline registers. They are assumed stable across each rising edge, and they read no meaning into a destination index when its write enable is low. A bubble is assumed to appear as a cleared write enable, a cleared use flag and a cleared branch flag, never as a stray index with an enable set. The stimulus drives every input on the falling edge, both from a vector table and from a small stage-register model that shifts instructions exactly as the controller commands. Bubbles in that model always carry cleared flags, so the inputs at each rising edge are a consistent pipeline snapshot.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_disable,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output fwd_sel_e         sel
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic src_live;
  logic mem_hit;
  logic wb_hit;

  assign src_live = (src_idx != ZERO_IDX) && !fwd_disable;
  assign mem_hit  = src_live && mem_we && (mem_rd == src_idx);
  assign wb_hit   = src_live && wb_we && (wb_rd == src_idx);

  always_comb begin
    if (mem_hit)     sel = FWD_MEM;
    else if (wb_hit) sel = FWD_WB;
    else             sel = FWD_RF;
  end

  AST_ZERO_NEVER_FWD: assert property (@(posedge clk) disable iff (rst)
    (src_idx == ZERO_IDX) |-> (sel == FWD_RF)); // R3
  AST_DISABLED_USES_RF: assert property (@(posedge clk) disable iff (rst)
    fwd_disable |-> (sel == FWD_RF)); // R7
  AST_MEM_OVER_WB: assert property (@(posedge clk) disable iff (rst)
    (!fwd_disable && mem_we && wb_we && mem_rd == src_idx && wb_rd == src_idx
     && src_idx != ZERO_IDX) |-> (sel == FWD_MEM)); // R2
  AST_IDLE_WRITERS_RF: assert property (@(posedge clk) disable iff (rst)
    (!mem_we && !wb_we) |-> (sel == FWD_RF)); // R4
endmodule

// File: rtl/hzd_stall_det.sv
module hzd_stall_det #(
  parameter int IDX_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            fwd_disable,
  input  logic [NUM_SRC-1:0][IDX_W-1:0]   dec_src,
  input  logic [NUM_SRC-1:0]              dec_use,
  input  logic [IDX_W-1:0]                ex_rd,
  input  logic                            ex_we,
  input  logic                            ex_is_load,
  input  logic [IDX_W-1:0]                mem_rd,
  input  logic                            mem_we,
  output logic                            stall_req
);
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic [NUM_SRC-1:0] src_stall;
  logic               ex_writes;
  logic               mem_writes;

  assign ex_writes  = ex_we && (ex_rd != ZERO_IDX);
  assign mem_writes = mem_we && (mem_rd != ZERO_IDX);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic hit_ex;
    logic hit_mem;
    assign hit_ex  = dec_use[g] && ex_writes && (ex_rd == dec_src[g]);
    assign hit_mem = dec_use[g] && mem_writes && (mem_rd == dec_src[g]);
    always_comb begin
      if (fwd_disable) src_stall[g] = hit_ex || hit_mem;
      else             src_stall[g] = hit_ex && ex_is_load;
    end
  end

  assign stall_req = |src_stall;

  AST_UNUSED_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (dec_use == '0) |-> !stall_req); // R6
  AST_NO_WRITER_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!ex_we && !mem_we) |-> !stall_req); // R4
  AST_FWD_ALU_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!fwd_disable && !ex_is_load) |-> !stall_req); // R5
endmodule

// File: rtl/hzd_flush_arb.sv
module hzd_flush_arb (
  input  logic clk,
  input  logic rst,
  input  logic stall_req,
  input  logic br_taken,
  output logic pc_hold,
  output logic fd_hold,
  output logic fd_flush,
  output logic de_bubble
);
  logic do_stall;

  assign do_stall  = stall_req && !br_taken;
  assign pc_hold   = do_stall;
  assign fd_hold   = do_stall;
  assign fd_flush  = br_taken;
  assign de_bubble = do_stall || br_taken;

  AST_FLUSH_BEATS_STALL: assert property (@(posedge clk) disable iff (rst)
    (br_taken && stall_req) |-> (!pc_hold && !fd_hold && fd_flush)); // R8
  AST_STALL_INSERTS_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    pc_hold |-> (de_bubble && fd_hold && !fd_flush)); // R5
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
  import hzd_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwd_disable,
  input  logic [IDX_W-1:0] dec_rs1,
  input  logic [IDX_W-1:0] dec_rs2,
  input  logic             dec_use_rs1,
  input  logic             dec_use_rs2,
  input  logic [IDX_W-1:0] ex_rs1,
  input  logic [IDX_W-1:0] ex_rs2,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_is_load,
  input  logic             ex_br_taken,
  input  logic [IDX_W-1:0] mem_rd,
  input  logic             mem_we,
  input  logic [IDX_W-1:0] wb_rd,
  input  logic             wb_we,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             pc_hold,
  output logic             fd_hold,
  output logic             fd_flush,
  output logic             de_bubble
);
  localparam int NUM_OPS = 2;

  logic [NUM_OPS-1:0][IDX_W-1:0] ex_src;
  logic [NUM_OPS-1:0][IDX_W-1:0] dec_src;
  logic [NUM_OPS-1:0]            dec_use;
  fwd_sel_e                      op_sel [NUM_OPS];
  logic                          stall_req;

  assign ex_src  = {ex_rs2, ex_rs1};
  assign dec_src = {dec_rs2, dec_rs1};
  assign dec_use = {dec_use_rs2, dec_use_rs1};

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    hzd_fwd_sel #(.IDX_W(IDX_W)) i_fwd_sel (
      .clk         (clk),
      .rst         (rst),
      .fwd_disable (fwd_disable),
      .src_idx     (ex_src[g]),
      .mem_rd      (mem_rd),
      .mem_we      (mem_we),
      .wb_rd       (wb_rd),
      .wb_we       (wb_we),
      .sel         (op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  hzd_stall_det #(.IDX_W(IDX_W), .NUM_SRC(NUM_OPS)) i_stall_det (
    .clk         (clk),
    .rst         (rst),
    .fwd_disable (fwd_disable),
    .dec_src     (dec_src),
    .dec_use     (dec_use),
    .ex_rd       (ex_rd),
    .ex_we       (ex_we),
    .ex_is_load  (ex_is_load),
    .mem_rd      (mem_rd),
    .mem_we      (mem_we),
    .stall_req   (stall_req)
  );

  hzd_flush_arb i_flush_arb (
    .clk       (clk),
    .rst       (rst),
    .stall_req (stall_req),
    .br_taken  (ex_br_taken),
    .pc_hold   (pc_hold),
    .fd_hold   (fd_hold),
    .fd_flush  (fd_flush),
    .de_bubble (de_bubble)
  );

  AST_BRANCH_CLEARS_TWO: assert property (@(posedge clk) disable iff (rst)
    ex_br_taken |-> (fd_flush && de_bubble && !pc_hold)); // R8
  AST_LOAD_USE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!fwd_disable && !ex_br_taken && ex_we && ex_is_load && dec_use_rs1
     && ex_rd != '0 && dec_rs1 == ex_rd) |-> (pc_hold && de_bubble)); // R5
  AST_HOLDS_NEED_PRODUCER: assert property (@(posedge clk) disable iff (rst)
    (!ex_we && !mem_we && !ex_br_taken) |-> (!pc_hold && !de_bubble && !fd_flush)); // R9
endmodule

// File: tb/test_hazard_ctrl_unit.sv
module test_hazard_ctrl_unit;
  localparam int W = 5;

  logic clk = 1'b0;
  logic rst;
  logic dis;
  logic [W-1:0] drs1, drs2, ers1, ers2, erd, mrd, wrd;
  logic du1, du2, ewe, eld, ebt, mwe, wwe;
  logic [1:0] sel_a, sel_b;
  logic pc_hold, fd_hold, fd_flush, de_bubble;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hazard_ctrl_unit #(.IDX_W(W)) i_hazard_ctrl_unit (
    .clk(clk), .rst(rst), .fwd_disable(dis),
    .dec_rs1(drs1), .dec_rs2(drs2), .dec_use_rs1(du1), .dec_use_rs2(du2),
    .ex_rs1(ers1), .ex_rs2(ers2), .ex_rd(erd), .ex_we(ewe), .ex_is_load(eld),
    .ex_br_taken(ebt), .mem_rd(mrd), .mem_we(mwe), .wb_rd(wrd), .wb_we(wwe),
    .fwd_a_sel(sel_a), .fwd_b_sel(sel_b), .pc_hold(pc_hold), .fd_hold(fd_hold),
    .fd_flush(fd_flush), .de_bubble(de_bubble)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below 5000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0] req;
    logic dis;
    logic [4:0] drs1; logic [4:0] drs2; logic du1; logic du2;
    logic [4:0] ers1; logic [4:0] ers2; logic [4:0] erd;
    logic ewe; logic eld; logic ebt;
    logic [4:0] mrd; logic mwe; logic [4:0] wrd; logic wwe;
    logic [1:0] ea; logic [1:0] eb; logic eh; logic ef;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{4'd9, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R9 idle
    '{4'd1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd3, 5'd4, 5'd0, 1'b0, 1'b0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b01, 2'b00, 1'b0, 1'b0}, // R1 a from mem
    '{4'd1, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd4, 5'd0, 1'b0, 1'b0, 1'b0, 5'd4, 1'b1, 5'd0, 1'b0, 2'b00, 2'b01, 1'b0, 1'b0}, // R1 b from mem
    '{4'd2, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd5, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0}, // R2 a from wb
    '{4'd2, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd6, 5'd6, 5'd0, 1'b0, 1'b0, 1'b0, 5'd6, 1'b1, 5'd6, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0}, // R2 mem beats wb
    '{4'd2, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd7, 5'd8, 5'd0, 1'b0, 1'b0, 1'b0, 5'd8, 1'b1, 5'd7, 1'b1, 2'b10, 2'b01, 1'b0, 1'b0}, // R2 split
    '{4'd3, 1'b0, 5'd0, 5'd0, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 1'b1, 1'b1, 1'b0, 5'd0, 1'b1, 5'd0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0}, // R3 reg zero
    '{4'd4, 1'b0, 5'd9, 5'd0, 1'b1, 1'b0, 5'd9, 5'd0, 5'd9, 1'b0, 1'b1, 1'b0, 5'd9, 1'b0, 5'd9, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R4 enables low
    '{4'd5, 1'b0, 5'd10, 5'd0, 1'b1, 1'b0, 5'd0, 5'd0, 5'd10, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R5 load-use rs1
    '{4'd5, 1'b0, 5'd0, 5'd11, 1'b0, 1'b1, 5'd0, 5'd0, 5'd11, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R5 load-use rs2
    '{4'd5, 1'b0, 5'd12, 5'd0, 1'b1, 1'b0, 5'd0, 5'd0, 5'd12, 1'b1, 1'b0, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R5 alu no stall
    '{4'd5, 1'b0, 5'd18, 5'd0, 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd18, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R5 mem no stall
    '{4'd6, 1'b0, 5'd13, 5'd13, 1'b0, 1'b0, 5'd0, 5'd0, 5'd13, 1'b1, 1'b1, 1'b0, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0}, // R6 unused src
    '{4'd7, 1'b1, 5'd14, 5'd0, 1'b1, 1'b0, 5'd3, 5'd0, 5'd14, 1'b1, 1'b0, 1'b0, 5'd3, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R7 ex stall
    '{4'd7, 1'b1, 5'd0, 5'd15, 1'b0, 1'b1, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd15, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0}, // R7 mem stall
    '{4'd7, 1'b1, 5'd16, 5'd0, 1'b1, 1'b0, 5'd16, 5'd0, 5'd0, 1'b0, 1'b0, 1'b0, 5'd0, 1'b0, 5'd16, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0}, // R7 wb no stall
    '{4'd8, 1'b0, 5'd17, 5'd0, 1'b1, 1'b0, 5'd0, 5'd0, 5'd17, 1'b1, 1'b1, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1}, // R8 beats load-use
    '{4'd8, 1'b0, 5'd0, 5'd0, 1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1}, // R8 plain
    '{4'd8, 1'b1, 5'd19, 5'd0, 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 1'b0, 1'b0, 1'b1, 5'd19, 1'b1, 5'd0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1}  // R8 beats nofwd
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    dis = 0; drs1 = 0; drs2 = 0; du1 = 0; du2 = 0; ers1 = 0; ers2 = 0; erd = 0;
    ewe = 0; eld = 0; ebt = 0; mrd = 0; mwe = 0; wrd = 0; wwe = 0;
  endtask

  // stage-register model
  int p_rd [4];
  int p_rs [4];
  bit p_ld [4];
  bit p_bt [4];
  int p_tgt;

  task automatic run_prog(input int n, input bit nofwd, output int stalls,
                          output int retired, output int sel_at_e1);
    int sd = -1, se = -1, sm = -1, sw = -1, pc = 0;
    stalls = 0; retired = 0; sel_at_e1 = -1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      dis  = nofwd;
      drs1 = (sd >= 0) ? W'(p_rs[sd]) : '0; du1 = (sd >= 0); drs2 = '0; du2 = 0;
      ers1 = (se >= 0) ? W'(p_rs[se]) : '0; ers2 = '0;
      erd  = (se >= 0) ? W'(p_rd[se]) : '0; ewe = (se >= 0) && !p_bt[se];
      eld  = (se >= 0) && p_ld[se]; ebt = (se >= 0) && p_bt[se];
      mrd  = (sm >= 0) ? W'(p_rd[sm]) : '0; mwe = (sm >= 0) && !p_bt[sm];
      wrd  = (sw >= 0) ? W'(p_rd[sw]) : '0; wwe = (sw >= 0) && !p_bt[sw];
      #2;
      if (pc_hold) stalls++;
      if (se == 1) sel_at_e1 = int'(sel_a);
      if (sw >= 0) retired++;
      sw = sm; sm = se;
      if (fd_flush) begin
        se = -1; sd = -1; pc = p_tgt;
      end else if (pc_hold) begin
        se = -1;
      end else begin
        se = sd; sd = (pc < n) ? pc : -1; if (pc < n) pc++;
      end
      if (pc >= n && sd < 0 && se < 0 && sm < 0 && sw < 0) break;
    end
  endtask

  initial begin
    int st, rt, sl;
    idle_inputs();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R9 reset controls", {pc_hold, fd_hold, fd_flush, de_bubble}, 0);
    check("R9 reset selects", {sel_a, sel_b}, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      dis = TBL[i].dis; drs1 = TBL[i].drs1; drs2 = TBL[i].drs2;
      du1 = TBL[i].du1; du2 = TBL[i].du2; ers1 = TBL[i].ers1; ers2 = TBL[i].ers2;
      erd = TBL[i].erd; ewe = TBL[i].ewe; eld = TBL[i].eld; ebt = TBL[i].ebt;
      mrd = TBL[i].mrd; mwe = TBL[i].mwe; wrd = TBL[i].wrd; wwe = TBL[i].wwe;
      #2;
      check($sformatf("R%0d vec%0d sel_a", TBL[i].req, i), sel_a, TBL[i].ea);
      check($sformatf("R%0d vec%0d sel_b", TBL[i].req, i), sel_b, TBL[i].eb);
      check($sformatf("R%0d vec%0d ctrl", TBL[i].req, i),
            {pc_hold, fd_hold, fd_flush, de_bubble},
            TBL[i].ef ? 4'b0011 : (TBL[i].eh ? 4'b1101 : 4'b0000));
    end

    // R7: producer then dependent, bypassing off: two stalls
    p_rd = '{3, 9, 0, 0}; p_rs = '{0, 3, 0, 0}; p_ld = '{0, 0, 0, 0}; p_bt = '{0, 0, 0, 0}; p_tgt = 0;
    run_prog(2, 1'b1, st, rt, sl);
    check("R7 back-to-back stalls", st, 2);
    check("R7 select with bypass off", sl, 0);

    // R5: load then dependent: one stall, operand from writeback
    p_ld = '{1, 0, 0, 0};
    run_prog(2, 1'b0, st, rt, sl);
    check("R5 load-use stalls", st, 1);
    check("R5 load-use select wb", sl, 2);

    // R1: ALU producer then dependent: no stall, operand from memory stage
    p_ld = '{0, 0, 0, 0};
    run_prog(2, 1'b0, st, rt, sl);
    check("R1 alu dependent stalls", st, 0);
    check("R1 alu dependent select mem", sl, 1);

    // R8: taken branch skips the two younger instructions
    p_rd = '{0, 4, 5, 6}; p_rs = '{0, 0, 0, 0}; p_bt = '{1, 0, 0, 0}; p_tgt = 3;
    run_prog(4, 1'b0, st, rt, sl);
    check("R8 retired after branch", rt, 2);
    check("R8 flushed never in execute", sl, -1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule